// File: doc/BRIEF.md
# Gated Split-Radix Butterfly Unit

This block is the arithmetic core of a shared-memory split-radix FFT engine. Each clock it accepts one pair of complex samples, one from each data bank, and forms a halved sum (upper leg) and a halved difference (lower leg). Each leg then passes through its own post-operation: unchanged, rotated by a quarter turn, or multiplied by a full complex twiddle value. The quarter turn is done by exchanging the real and imaginary parts and negating one of them, so it never uses a multiplier.

Each leg owns one complex multiplier. The operand registers that feed a multiplier load only when that leg has a sample in full-multiply mode. When no multiply is needed the multiplier inputs stay frozen and the multiplier logic does not toggle. Results come out on registered ports at a fixed latency, whatever the modes, so the write-back address pipeline of the surrounding engine can be a plain delay line.

Samples are 16-bit signed real and 16-bit signed imaginary parts. Twiddles use Q1.15 scaling.

Top module: `sr_bfly_gated`

## Requirements
- R1: While `rst_n` is low, and after it is released with no input accepted, `out_valid` is 0 and all four result ports are 0.
- R2: A sample accepted with `in_valid` high at a rising edge produces `out_valid` high after the next rising edge, and low again after the one after that unless another sample follows. Back-to-back samples emerge in order, one per cycle.
- R3: The upper-leg base value is floor((a+b)/2) and the lower-leg base value is floor((a-b)/2), computed separately on the real and imaginary parts.
- R4: Leg mode code 2'b00 outputs the leg base value unchanged.
- R5: Leg mode code 2'b01 outputs (base_im, -base_re). This is multiplication by -j. A negated -32768 saturates to 32767.
- R6: Leg mode code 2'b10 outputs the complex product of the base value and that leg's twiddle inputs.
  - The real part is the saturated value of (re*wre - im*wim + 16384) >> 15.
  - The imaginary part is the saturated value of (re*wim + im*wre + 16384) >> 15.
  - The shifts are arithmetic, and saturation is to the 16-bit signed range.
- R7: Leg mode code 2'b11 behaves exactly as code 2'b00.
- R8: The upper and lower legs select their modes independently. The mode and twiddle of one leg have no effect on the other leg's result.
- R9: In a cycle where `out_valid` is low, the four result ports keep their previous values.
- R10: A leg's multiplier operand registers, both base and twiddle, change only at an edge that accepts a sample in which that leg's mode is 2'b10. A multiply that follows a run of non-multiply samples uses the fresh operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample pair present |
| a_re | input | 16 | First sample, real part (signed) |
| a_im | input | 16 | First sample, imaginary part (signed) |
| b_re | input | 16 | Second sample, real part (signed) |
| b_im | input | 16 | Second sample, imaginary part (signed) |
| up_mode | input | 2 | Upper-leg operation: 00 pass, 01 -j rotate, 10 multiply, 11 pass |
| lo_mode | input | 2 | Lower-leg operation, same coding |
| up_tw_re | input | 16 | Upper-leg twiddle real part, Q1.15 |
| up_tw_im | input | 16 | Upper-leg twiddle imaginary part, Q1.15 |
| lo_tw_re | input | 16 | Lower-leg twiddle real part, Q1.15 |
| lo_tw_im | input | 16 | Lower-leg twiddle imaginary part, Q1.15 |
| out_valid | output | 1 | Result ports carry a new result |
| up_re | output | 16 | Upper-leg result, real part |
| up_im | output | 16 | Upper-leg result, imaginary part |
| lo_re | output | 16 | Lower-leg result, real part |
| lo_im | output | 16 | Lower-leg result, imaginary part |

## Verification
A corrupted stage-one mode or base register appears at the result ports on the very next edge, as a wrong value in a leg whose mode is known. A lost valid bit shows as `out_valid` missing two edges after acceptance. A multiplier operand register that fails to load shows up only on the next multiply in that leg: the product is then formed from stale operands. For that reason the sweep places multiply cycles right after bypass and rotate cycles carrying different data. The sweep covers every pair of leg modes over saturating corner values and pseudo-random data, and a streaming run checks ordering under back-to-back input.

// File: rtl/sr_bfly_gated.sv
module sr_bfly_gated #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  input  logic [1:0]          up_mode,
  input  logic [1:0]          lo_mode,
  input  logic signed [W-1:0] up_tw_re,
  input  logic signed [W-1:0] up_tw_im,
  input  logic signed [W-1:0] lo_tw_re,
  input  logic signed [W-1:0] lo_tw_im,
  output logic                out_valid,
  output logic signed [W-1:0] up_re,
  output logic signed [W-1:0] up_im,
  output logic signed [W-1:0] lo_re,
  output logic signed [W-1:0] lo_im
);
  localparam int PW = 2*W + 1;
  localparam logic [1:0] M_SWAP = 2'b01;
  localparam logic [1:0] M_MUL  = 2'b10;
  localparam logic signed [W-1:0]  S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [PW-1:0] RND   = PW'(2**(W-2));

  logic signed [W:0] sum_re, sum_im, dif_re, dif_im;
  assign sum_re = {a_re[W-1], a_re} + {b_re[W-1], b_re};
  assign sum_im = {a_im[W-1], a_im} + {b_im[W-1], b_im};
  assign dif_re = {a_re[W-1], a_re} - {b_re[W-1], b_re};
  assign dif_im = {a_im[W-1], a_im} - {b_im[W-1], b_im};

  logic                v1;
  logic [1:0]          up_md, lo_md;
  logic signed [W-1:0] up_base_re, up_base_im, lo_base_re, lo_base_im;
  logic signed [W-1:0] up_op_re, up_op_im, up_twq_re, up_twq_im;
  logic signed [W-1:0] lo_op_re, lo_op_im, lo_twq_re, lo_twq_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1         <= 1'b0;
      up_md      <= '0;
      lo_md      <= '0;
      up_base_re <= '0;
      up_base_im <= '0;
      lo_base_re <= '0;
      lo_base_im <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        up_md      <= up_mode;
        lo_md      <= lo_mode;
        up_base_re <= sum_re[W:1];
        up_base_im <= sum_im[W:1];
        lo_base_re <= dif_re[W:1];
        lo_base_im <= dif_im[W:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_op_re  <= '0;
      up_op_im  <= '0;
      up_twq_re <= '0;
      up_twq_im <= '0;
    end else if (in_valid && up_mode == M_MUL) begin
      up_op_re  <= sum_re[W:1];
      up_op_im  <= sum_im[W:1];
      up_twq_re <= up_tw_re;
      up_twq_im <= up_tw_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_op_re  <= '0;
      lo_op_im  <= '0;
      lo_twq_re <= '0;
      lo_twq_im <= '0;
    end else if (in_valid && lo_mode == M_MUL) begin
      lo_op_re  <= dif_re[W:1];
      lo_op_im  <= dif_im[W:1];
      lo_twq_re <= lo_tw_re;
      lo_twq_im <= lo_tw_im;
    end
  end

  function automatic logic signed [W-1:0] clip(input logic signed [PW-1:0] v);
    if (v > PW'(S_MAX)) return S_MAX;
    if (v < PW'(S_MIN)) return S_MIN;
    return v[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] dot(
    input logic signed [W-1:0] a, input logic signed [W-1:0] b,
    input logic signed [W-1:0] c, input logic signed [W-1:0] d,
    input logic sub);
    logic signed [PW-1:0] p, q, t;
    p = PW'(a) * PW'(b);
    q = PW'(c) * PW'(d);
    t = (sub ? p - q : p + q) + RND;
    return clip(t >>> (W-1));
  endfunction

  function automatic logic signed [W-1:0] negclip(input logic signed [W-1:0] x);
    return (x == S_MIN) ? S_MAX : -x;
  endfunction

  logic signed [W-1:0] up_m_re, up_m_im, lo_m_re, lo_m_im;
  assign up_m_re = dot(up_op_re, up_twq_re, up_op_im, up_twq_im, 1'b1);
  assign up_m_im = dot(up_op_re, up_twq_im, up_op_im, up_twq_re, 1'b0);
  assign lo_m_re = dot(lo_op_re, lo_twq_re, lo_op_im, lo_twq_im, 1'b1);
  assign lo_m_im = dot(lo_op_re, lo_twq_im, lo_op_im, lo_twq_re, 1'b0);

  logic signed [W-1:0] up_sel_re, up_sel_im, lo_sel_re, lo_sel_im;

  always_comb begin
    case (up_md)
      M_SWAP:  begin up_sel_re = up_base_im; up_sel_im = negclip(up_base_re); end
      M_MUL:   begin up_sel_re = up_m_re;    up_sel_im = up_m_im;             end
      default: begin up_sel_re = up_base_re; up_sel_im = up_base_im;          end
    endcase
  end

  always_comb begin
    case (lo_md)
      M_SWAP:  begin lo_sel_re = lo_base_im; lo_sel_im = negclip(lo_base_re); end
      M_MUL:   begin lo_sel_re = lo_m_re;    lo_sel_im = lo_m_im;             end
      default: begin lo_sel_re = lo_base_re; lo_sel_im = lo_base_im;          end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      up_re     <= '0;
      up_im     <= '0;
      lo_re     <= '0;
      lo_im     <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        up_re <= up_sel_re;
        up_im <= up_sel_im;
        lo_re <= lo_sel_re;
        lo_im <= lo_sel_im;
      end
    end
  end
endmodule

// File: rtl/sr_bfly_gated_chk.sv
module sr_bfly_gated_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          up_mode,
  input logic [1:0]          lo_mode,
  input logic                out_valid,
  input logic signed [W-1:0] up_re,
  input logic signed [W-1:0] up_im,
  input logic signed [W-1:0] lo_re,
  input logic signed [W-1:0] lo_im,
  input logic                v1,
  input logic [1:0]          up_md,
  input logic [1:0]          lo_md,
  input logic signed [W-1:0] up_base_re,
  input logic signed [W-1:0] up_base_im,
  input logic signed [W-1:0] lo_base_re,
  input logic signed [W-1:0] lo_base_im,
  input logic signed [W-1:0] up_op_re,
  input logic signed [W-1:0] up_op_im,
  input logic signed [W-1:0] up_twq_re,
  input logic signed [W-1:0] up_twq_im,
  input logic signed [W-1:0] lo_op_re,
  input logic signed [W-1:0] lo_op_im,
  input logic signed [W-1:0] lo_twq_re,
  input logic signed [W-1:0] lo_twq_im
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !out_valid) |->
      ($stable(up_re) && $stable(up_im) && $stable(lo_re) && $stable(lo_im)));

  p_up_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && up_mode == 2'b10) |=>
      ($stable(up_op_re) && $stable(up_op_im) && $stable(up_twq_re) && $stable(up_twq_im)));

  p_lo_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && lo_mode == 2'b10) |=>
      ($stable(lo_op_re) && $stable(lo_op_im) && $stable(lo_twq_re) && $stable(lo_twq_im)));

  p_up_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && up_md == 2'b01) |=> (up_re == $past(up_base_im)));

  p_lo_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && lo_md == 2'b00) |=> (lo_re == $past(lo_base_re) && lo_im == $past(lo_base_im)));

  p_up_spare_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && up_md == 2'b11) |=> (up_re == $past(up_base_re) && up_im == $past(up_base_im)));
endmodule

bind sr_bfly_gated sr_bfly_gated_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .up_mode(up_mode), .lo_mode(lo_mode),
  .out_valid(out_valid), .up_re(up_re), .up_im(up_im), .lo_re(lo_re), .lo_im(lo_im),
  .v1(v1), .up_md(up_md), .lo_md(lo_md),
  .up_base_re(up_base_re), .up_base_im(up_base_im),
  .lo_base_re(lo_base_re), .lo_base_im(lo_base_im),
  .up_op_re(up_op_re), .up_op_im(up_op_im), .up_twq_re(up_twq_re), .up_twq_im(up_twq_im),
  .lo_op_re(lo_op_re), .lo_op_im(lo_op_im), .lo_twq_re(lo_twq_re), .lo_twq_im(lo_twq_im)
);

// File: tb/tb_sr_bfly_gated.sv
`timescale 1ns/1ps
module tb_sr_bfly_gated;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic [1:0] up_mode = '0, lo_mode = '0;
  logic signed [15:0] up_tw_re = '0, up_tw_im = '0, lo_tw_re = '0, lo_tw_im = '0;
  logic out_valid;
  logic signed [15:0] up_re, up_im, lo_re, lo_im;

  always #4 clk = ~clk;

  sr_bfly_gated dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .up_mode(up_mode), .lo_mode(lo_mode),
    .up_tw_re(up_tw_re), .up_tw_im(up_tw_im), .lo_tw_re(lo_tw_re), .lo_tw_im(lo_tw_im),
    .out_valid(out_valid), .up_re(up_re), .up_im(up_im), .lo_re(lo_re), .lo_im(lo_im)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int half(input int v);
    return v >>> 1;
  endfunction

  task automatic ref_leg(input int br, input int bi, input int wr, input int wi,
                         input logic [1:0] md, output int rr, output int ri);
    case (md)
      2'b01: begin rr = bi; ri = sat(-longint'(br)); end
      2'b10: begin
        rr = sat((longint'(br) * wr - longint'(bi) * wi + 16384) >>> 15);
        ri = sat((longint'(br) * wi + longint'(bi) * wr + 16384) >>> 15);
      end
      default: begin rr = br; ri = bi; end
    endcase
  endtask

  function automatic string tag(input logic [1:0] md);
    case (md)
      2'b00: return "R3 R4";
      2'b01: return "R5";
      2'b10: return "R6 R10";
      default: return "R7";
    endcase
  endfunction

  function automatic int rnd16();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'($signed(lfsr[15:0]));
  endfunction

  task automatic compute(input int ar, input int ai, input int br, input int bi,
                         input int uwr, input int uwi, input int lwr, input int lwi,
                         input logic [1:0] um, input logic [1:0] lm,
                         output int eur, output int eui, output int elr, output int eli);
    ref_leg(half(ar + br), half(ai + bi), uwr, uwi, um, eur, eui);
    ref_leg(half(ar - br), half(ai - bi), lwr, lwi, lm, elr, eli);
  endtask

  task automatic drive(input int ar, input int ai, input int br, input int bi,
                       input int uwr, input int uwi, input int lwr, input int lwi,
                       input logic [1:0] um, input logic [1:0] lm);
    in_valid = 1'b1;
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
    up_tw_re = 16'(uwr); up_tw_im = 16'(uwi); lo_tw_re = 16'(lwr); lo_tw_im = 16'(lwi);
    up_mode = um; lo_mode = lm;
  endtask

  task automatic one_op(input int ar, input int ai, input int br, input int bi,
                        input int uwr, input int uwi, input int lwr, input int lwi,
                        input logic [1:0] um, input logic [1:0] lm);
    int eur, eui, elr, eli;
    compute(ar, ai, br, bi, uwr, uwi, lwr, lwi, um, lm, eur, eui, elr, eli);
    drive(ar, ai, br, bi, uwr, uwi, lwr, lwi, um, lm);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    a_re = 16'(rnd16()); b_re = 16'(rnd16());
    up_tw_re = 16'(rnd16()); lo_tw_im = 16'(rnd16());
    up_mode = 2'(rnd16()); lo_mode = 2'(rnd16());
    check("R2", "out_valid one edge after accept", int'(out_valid), 0);
    @(posedge clk);
    @(negedge clk);
    check("R2", "out_valid two edges after accept", int'(out_valid), 1);
    check(tag(um), "upper re", int'(up_re), eur);
    check(tag(um), "upper im", int'(up_im), eui);
    check({tag(lm), " R8"}, "lower re", int'(lo_re), elr);
    check({tag(lm), " R8"}, "lower im", int'(lo_im), eli);
    @(posedge clk);
    @(negedge clk);
    check("R2", "out_valid drops", int'(out_valid), 0);
    check("R9", "upper re held", int'(up_re), eur);
    check("R9", "lower im held", int'(lo_im), eli);
  endtask

  int corner [6] = '{-32768, 32767, 0, -1, 1, 16384};

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "upper re in reset", int'(up_re), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "out_valid after release", int'(out_valid), 0);
    check("R1", "lower im after release", int'(lo_im), 0);

    one_op(-32768, 0, -32768, 0, -32768, 0, -32768, 0, 2'b10, 2'b10);
    one_op(32767, -32768, -32768, -32768, 0, 0, 0, 0, 2'b01, 2'b01);

    for (int p = 0; p < 40; p++) begin
      for (int m = 0; m < 16; m++) begin
        int ar, ai, br, bi, uwr, uwi, lwr, lwi;
        if (p < 8) begin
          ar = corner[(p + m) % 6];     ai = corner[(p + 2) % 6];
          br = corner[(p * 5 + m) % 6]; bi = corner[(p + m + 3) % 6];
          uwr = corner[(m + 1) % 6];    uwi = corner[(p + 4) % 6];
          lwr = corner[(m + p) % 6];    lwi = corner[(m * 3 + 5) % 6];
        end else begin
          ar = rnd16(); ai = rnd16(); br = rnd16(); bi = rnd16();
          uwr = rnd16(); uwi = rnd16(); lwr = rnd16(); lwi = rnd16();
        end
        one_op(ar, ai, br, bi, uwr, uwi, lwr, lwi, 2'(m >> 2), 2'(m));
      end
    end

    begin
      int er [12][4];
      for (int i = 0; i <= 12; i++) begin
        if (i < 12) begin
          int ar, ai, br, bi, uwr, uwi, lwr, lwi;
          logic [1:0] um, lm;
          ar = rnd16(); ai = rnd16(); br = rnd16(); bi = rnd16();
          uwr = rnd16(); uwi = rnd16(); lwr = rnd16(); lwi = rnd16();
          um = 2'(i); lm = 2'(i + 2);
          compute(ar, ai, br, bi, uwr, uwi, lwr, lwi, um, lm, er[i][0], er[i][1], er[i][2], er[i][3]);
          drive(ar, ai, br, bi, uwr, uwi, lwr, lwi, um, lm);
        end else begin
          in_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        if (i >= 1) begin
          check("R2", "stream valid", int'(out_valid), 1);
          check("R2 R8", "stream upper re", int'(up_re), er[i-1][0]);
          check("R2 R8", "stream upper im", int'(up_im), er[i-1][1]);
          check("R2 R8", "stream lower re", int'(lo_re), er[i-1][2]);
          check("R2 R8", "stream lower im", int'(lo_im), er[i-1][3]);
        end
      end
      @(posedge clk);
      @(negedge clk);
      check("R2", "stream valid drops", int'(out_valid), 0);
      check("R9", "stream lower re held", int'(lo_re), er[11][2]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule